// File: doc/BRIEF.md
# CPU Status and Exception-Save Register Unit

This unit keeps the processor status word of a small CPU core together with two save registers: an exception-save word and a shadow-save word. The status word carries an interrupt-enable bit, a user-mode bit, an exception-mode bit, an interrupt-handler-mode bit, an interrupt-level field, a current register-set field and a previous register-set field. The save registers hold the status that was live before the core entered a handler.

The core signals a non-interrupt exception with a one-cycle strobe. It offers a maskable interrupt with a request, a level, an optional shadow-set request and a target register set. The unit decides at once whether that interrupt may be taken. On entry it updates the status fields and, if the exception-mode bit was clear, saves the prior status. A return strobe restores status in one clock from whichever save register the last saving entry used. Software reads and writes all three words through a small control-register port.

Fields that are not built in the chosen configuration read back as 0, and the unit behaves as if they held 0.

Top module: `cpu_status_unit`

## Requirements
- R1: After reset, the status, exception-save and shadow-save words all read 0, and `irq_take_o` is 0.
- R2: `irq_take_o` is 1 exactly when `irq_i` is 1, the enable bit (bit 0) is 1 and `irq_level_i` is strictly greater than the level field (bits 9:4). With the enable bit at 0, no request is taken at any level.
- R3: Taking an interrupt sets the handler bit (bit 3) and the exception-mode bit (bit 2), and clears the enable bit and the user bit (bit 1). The level field is left as it was.
- R4: `exc_i` is acted on whatever the enable bit holds. It sets the exception-mode bit and clears the enable and user bits, and it leaves the handler bit unchanged. It wins over an interrupt that is taken in the same cycle.
- R5: On an entry with the exception-mode bit at 0, the status word before the entry is copied into the exception-save word, or into the shadow-save word when the entry is an interrupt with `irq_shadow_i` high. On an entry with the bit at 1, neither save word changes.
- R6: A taken interrupt with `irq_shadow_i` high loads `irq_set_i` into the current-set field (bits 15:10) and moves the old current-set value into the previous-set field (bits 21:16).
- R7: Software writes to the status word never change the current-set field. The other status fields take the written values.
- R8: `eret_i` restores the status word in one clock from the save word that the most recent saving entry used.
- R9: A status write with bits 1 and 2 both at 1 stores bit 2, forces bit 1 to 0, and raises `illegal_wr_o` for exactly the next cycle. The user and exception-mode bits are never both 1.
- R10: `csr_sel_i` selects a word: 0 selects status, 1 selects exception-save, 2 selects shadow-save, and 3 reads 0. The save words accept writes to bits 21:0, and bits 31:22 of every word read 0.
- R11: With memory management not built (`HAS_MMU`=0), the user and exception-mode bits read 0 and no illegal-write flag is raised. With shadow sets not built (`HAS_SHADOW`=0), the shadow-save word and both register-set fields read 0.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Control-register write strobe |
| csr_sel_i | input | 2 | Word select: 0 status, 1 exception-save, 2 shadow-save |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for the selected word |
| exc_i | input | 1 | Non-interrupt exception strobe (includes breaks) |
| irq_i | input | 1 | Maskable interrupt request |
| irq_level_i | input | LVL_W | Requested interrupt level |
| irq_shadow_i | input | 1 | The interrupt requests a shadow register set |
| irq_set_i | input | SET_W | Register set that the interrupt requests |
| eret_i | input | 1 | Return-from-exception strobe |
| irq_take_o | output | 1 | The offered interrupt is accepted in this cycle |
| status_o | output | 32 | Live status word |
| illegal_wr_o | output | 1 | One-cycle flag for a rejected user/exception-mode write |

## Verification
The bench builds two copies of the unit with the same stimulus. The first is the full configuration: memory management and shadow sets built, with 6-bit level and set fields. It gives the strict level compare, nested entries with the exception-mode bit already set, the choice between the two save words and the rejected user/exception-mode write. The second has `HAS_MMU`=0 and `HAS_SHADOW`=0. It shows that the fields which are not built read 0 and that the illegal-write flag stays quiet even when every bit is written to 1.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int XLEN = 32;

  localparam int PIE_B  = 0;
  localparam int U_B    = 1;
  localparam int EH_B   = 2;
  localparam int IH_B   = 3;
  localparam int IL_LSB = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ESAVE  = 2'd1,
    SEL_SSAVE  = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/csu_irq_gate.sv
module csu_irq_gate #(
  parameter int LVL_W = 6
) (
  input  logic             irq_i,
  input  logic             pie_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] il_i,
  output logic             take_o
);
  // strict compare: equal level is not taken
  assign take_o = irq_i & pie_i & (level_i > il_i);
endmodule

// File: rtl/csu_status_reg.sv
module csu_status_reg
  import csu_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int SET_W      = 6,
  parameter int HAS_MMU    = 1,
  parameter int HAS_SHADOW = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_i,
  input  logic             irq_take_i,
  input  logic             irq_shadow_i,
  input  logic [SET_W-1:0] irq_set_i,
  input  logic             eret_i,
  input  logic [XLEN-1:0]  restore_i,
  input  logic             wr_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  status_o,
  output logic             pie_o,
  output logic             eh_o,
  output logic [LVL_W-1:0] il_o,
  output logic             illegal_o
);
  localparam int CRS_LSB = IL_LSB + LVL_W;
  localparam int PRS_LSB = CRS_LSB + SET_W;
  localparam int USED_W  = PRS_LSB + SET_W;
  localparam bit MMU_EN  = (HAS_MMU != 0);
  localparam bit SH_EN   = (HAS_SHADOW != 0);

  logic             pie_q, u_q, eh_q, ih_q, illegal_q;
  logic [LVL_W-1:0] il_q;
  logic [SET_W-1:0] crs_q, prs_q;

  logic             pie_d, u_d, eh_d, ih_d, illegal_d;
  logic [LVL_W-1:0] il_d;
  logic [SET_W-1:0] crs_d, prs_d;

  always_comb begin
    pie_d     = pie_q;
    u_d       = u_q;
    eh_d      = eh_q;
    ih_d      = ih_q;
    il_d      = il_q;
    crs_d     = crs_q;
    prs_d     = prs_q;
    illegal_d = 1'b0;
    if (exc_i) begin
      eh_d  = 1'b1;
      pie_d = 1'b0;
      u_d   = 1'b0;
    end else if (irq_take_i) begin
      eh_d  = 1'b1;
      ih_d  = 1'b1;
      pie_d = 1'b0;
      u_d   = 1'b0;
      if (irq_shadow_i) begin
        prs_d = crs_q;
        crs_d = irq_set_i;
      end
    end else if (eret_i) begin
      pie_d = restore_i[PIE_B];
      eh_d  = restore_i[EH_B];
      u_d   = restore_i[U_B] & ~restore_i[EH_B];
      ih_d  = restore_i[IH_B];
      il_d  = restore_i[IL_LSB +: LVL_W];
      crs_d = restore_i[CRS_LSB +: SET_W];
      prs_d = restore_i[PRS_LSB +: SET_W];
    end else if (wr_i) begin
      pie_d     = wdata_i[PIE_B];
      eh_d      = wdata_i[EH_B];
      u_d       = wdata_i[U_B] & ~wdata_i[EH_B];
      ih_d      = wdata_i[IH_B];
      il_d      = wdata_i[IL_LSB +: LVL_W];
      prs_d     = wdata_i[PRS_LSB +: SET_W];
      illegal_d = MMU_EN & wdata_i[U_B] & wdata_i[EH_B];
    end
    if (!MMU_EN) begin
      u_d  = 1'b0;
      eh_d = 1'b0;
    end
    if (!SH_EN) begin
      crs_d = '0;
      prs_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pie_q     <= 1'b0;
      u_q       <= 1'b0;
      eh_q      <= 1'b0;
      ih_q      <= 1'b0;
      il_q      <= '0;
      crs_q     <= '0;
      prs_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      pie_q     <= pie_d;
      u_q       <= u_d;
      eh_q      <= eh_d;
      ih_q      <= ih_d;
      il_q      <= il_d;
      crs_q     <= crs_d;
      prs_q     <= prs_d;
      illegal_q <= illegal_d;
    end
  end

  assign status_o = {{(XLEN-USED_W){1'b0}}, prs_q, crs_q, il_q, ih_q, eh_q, u_q, pie_q};
  assign pie_o     = pie_q;
  assign eh_o      = eh_q;
  assign il_o      = il_q;
  assign illegal_o = illegal_q;

  AST_IRQ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && !exc_i) |=> (ih_q && !pie_q && !u_q && (eh_q || !MMU_EN) && il_q == $past(il_q))) // R3
    else $error("irq entry fields");
  AST_EXC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> (!pie_q && !u_q && (eh_q || !MMU_EN) && ih_q == $past(ih_q))) // R4
    else $error("exception entry fields");
  AST_CRS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(irq_take_i && !exc_i && irq_shadow_i) && !eret_i) |=> $stable(crs_q)) // R7
    else $error("current set changed");
  AST_SET_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SH_EN && irq_take_i && !exc_i && irq_shadow_i) |=> (crs_q == $past(irq_set_i) && prs_q == $past(crs_q))) // R6
    else $error("set swap");
  AST_NO_USER_EH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(u_q && eh_q)) // R9
    else $error("user and exception mode both set");
  AST_NO_MMU_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !MMU_EN |-> (!u_q && !eh_q && !illegal_q)) // R11
    else $error("mmu fields nonzero");
endmodule

// File: rtl/csu_save_regs.sv
module csu_save_regs
  import csu_pkg::*;
#(
  parameter int USED_W     = 22,
  parameter int HAS_SHADOW = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic            irq_take_i,
  input  logic            irq_shadow_i,
  input  logic            eh_i,
  input  logic [XLEN-1:0] status_i,
  input  logic            wr_e_i,
  input  logic            wr_s_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] esave_o,
  output logic [XLEN-1:0] ssave_o,
  output logic [XLEN-1:0] restore_o
);
  localparam bit SH_EN = (HAS_SHADOW != 0);
  localparam logic [XLEN-1:0] USED_MASK = {{(XLEN-USED_W){1'b0}}, {USED_W{1'b1}}};

  logic [XLEN-1:0] esave_q, ssave_q;
  logic            shadow_used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esave_q       <= '0;
      ssave_q       <= '0;
      shadow_used_q <= 1'b0;
    end else if (exc_i) begin
      if (!eh_i) begin
        esave_q       <= status_i;
        shadow_used_q <= 1'b0;
      end
    end else if (irq_take_i) begin
      if (!eh_i) begin
        if (SH_EN && irq_shadow_i) begin
          ssave_q       <= status_i;
          shadow_used_q <= 1'b1;
        end else begin
          esave_q       <= status_i;
          shadow_used_q <= 1'b0;
        end
      end
    end else begin
      if (wr_e_i)          esave_q <= wdata_i & USED_MASK;
      if (wr_s_i && SH_EN) ssave_q <= wdata_i & USED_MASK;
    end
  end

  assign esave_o   = esave_q;
  assign ssave_o   = ssave_q;
  assign restore_o = shadow_used_q ? ssave_q : esave_q;

  AST_SAVE_ON_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && !eh_i) |=> (esave_q == $past(status_i))) // R5
    else $error("exception save missing");
  AST_NO_NESTED_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_i || irq_take_i) && eh_i) |=> ($stable(esave_q) && $stable(ssave_q))) // R5
    else $error("nested entry overwrote save");
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((esave_q & ~USED_MASK) == '0 && (ssave_q & ~USED_MASK) == '0)) // R10
    else $error("reserved save bits set");
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import csu_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int SET_W      = 6,
  parameter int HAS_MMU    = 1,
  parameter int HAS_SHADOW = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_sel_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  input  logic             exc_i,
  input  logic             irq_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic             irq_shadow_i,
  input  logic [SET_W-1:0] irq_set_i,
  input  logic             eret_i,
  output logic             irq_take_o,
  output logic [31:0]      status_o,
  output logic             illegal_wr_o
);
  localparam int USED_W = IL_LSB + LVL_W + 2 * SET_W;

  csr_sel_e        sel;
  logic            pie, eh, wr_st, wr_e, wr_s;
  logic [LVL_W-1:0] il;
  logic [XLEN-1:0] status, esave, ssave, restore;

  assign sel   = csr_sel_e'(csr_sel_i);
  assign wr_st = csr_we_i && (sel == SEL_STATUS);
  assign wr_e  = csr_we_i && (sel == SEL_ESAVE);
  assign wr_s  = csr_we_i && (sel == SEL_SSAVE);

  csu_irq_gate #(.LVL_W(LVL_W)) u_gate (
    .irq_i  (irq_i),
    .pie_i  (pie),
    .level_i(irq_level_i),
    .il_i   (il),
    .take_o (irq_take_o)
  );

  csu_status_reg #(
    .LVL_W(LVL_W), .SET_W(SET_W), .HAS_MMU(HAS_MMU), .HAS_SHADOW(HAS_SHADOW)
  ) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_i       (exc_i),
    .irq_take_i  (irq_take_o),
    .irq_shadow_i(irq_shadow_i),
    .irq_set_i   (irq_set_i),
    .eret_i      (eret_i),
    .restore_i   (restore),
    .wr_i        (wr_st),
    .wdata_i     (csr_wdata_i),
    .status_o    (status),
    .pie_o       (pie),
    .eh_o        (eh),
    .il_o        (il),
    .illegal_o   (illegal_wr_o)
  );

  csu_save_regs #(.USED_W(USED_W), .HAS_SHADOW(HAS_SHADOW)) u_save (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_i       (exc_i),
    .irq_take_i  (irq_take_o),
    .irq_shadow_i(irq_shadow_i),
    .eh_i        (eh),
    .status_i    (status),
    .wr_e_i      (wr_e),
    .wr_s_i      (wr_s),
    .wdata_i     (csr_wdata_i),
    .esave_o     (esave),
    .ssave_o     (ssave),
    .restore_o   (restore)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: csr_rdata_o = status;
      SEL_ESAVE:  csr_rdata_o = esave;
      SEL_SSAVE:  csr_rdata_o = ssave;
      default:    csr_rdata_o = '0;
    endcase
  end

  assign status_o = status;

  AST_TAKE_NEEDS_PIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (irq_i && status_o[PIE_B])) // R2
    else $error("irq taken while disabled");
  AST_RETURN_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_i && !irq_take_o && !$past(restore[U_B] & restore[EH_B]))
      |=> (status_o[IH_B] == $past(restore[IH_B]) && status_o[9:4] == $past(restore[9:4]))) // R8
    else $error("return did not restore");
endmodule

// File: tb/cpu_status_unit_tb_top.sv
module cpu_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic        exc = 1'b0, irq = 1'b0, irq_shadow = 1'b0, eret = 1'b0;
  logic [5:0]  irq_level = '0, irq_set = '0;
  logic [31:0] rdata, status, rdata_nm, status_nm;
  logic        take, illegal, take_nm, illegal_nm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cpu_status_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_sel_i(csr_sel),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata), .exc_i(exc), .irq_i(irq),
    .irq_level_i(irq_level), .irq_shadow_i(irq_shadow), .irq_set_i(irq_set),
    .eret_i(eret), .irq_take_o(take), .status_o(status), .illegal_wr_o(illegal)
  );

  cpu_status_unit #(.HAS_MMU(0), .HAS_SHADOW(0)) dut_nm (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_sel_i(csr_sel),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata_nm), .exc_i(exc), .irq_i(irq),
    .irq_level_i(irq_level), .irq_shadow_i(irq_shadow), .irq_set_i(irq_set),
    .eret_i(eret), .irq_take_o(take_nm), .status_o(status_nm), .illegal_wr_o(illegal_nm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input string req, input logic [1:0] sel, input logic [31:0] exp);
    csr_sel = sel;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse_irq(input logic [5:0] lvl, input logic sh, input logic [5:0] set, input logic with_exc);
    @(negedge clk);
    irq = 1'b1; irq_level = lvl; irq_shadow = sh; irq_set = set; exc = with_exc;
    @(negedge clk);
    irq = 1'b0; irq_shadow = 1'b0; exc = 1'b0;
  endtask

  task automatic pulse_exc();
    @(negedge clk);
    exc = 1'b1;
    @(negedge clk);
    exc = 1'b0;
  endtask

  task automatic pulse_eret();
    @(negedge clk);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    csr_rd("R1 esave", 2'd1, 32'h0);
    csr_rd("R1 ssave", 2'd2, 32'h0);
    check("R1 take", {31'b0, take}, 32'h0);
  endtask

  task automatic t_write_status();
    // pie=1, il=5, attempt crs=3F, prs=3
    csr_wr(2'd0, 32'h0003_FC51);
    check("R7 crs read-only", status, 32'h0003_0051);
  endtask

  task automatic t_level_gate();
    @(negedge clk);
    irq = 1'b1; irq_level = 6'd5;
    #1 check("R2 equal level", {31'b0, take}, 32'h0);
    irq_level = 6'd6;
    #1 check("R2 higher level", {31'b0, take}, 32'h1);
    irq = 1'b0;
  endtask

  task automatic t_irq_entry();
    pulse_irq(6'd7, 1'b0, 6'd0, 1'b0);
    check("R3 irq entry", status, 32'h0003_005C);
    csr_rd("R5 esave copy", 2'd1, 32'h0003_0051);
    pulse_eret();
    check("R8 restore esave", status, 32'h0003_0051);
  endtask

  task automatic t_shadow_nested();
    csr_wr(2'd1, 32'h0000_0123);
    pulse_irq(6'd9, 1'b1, 6'd4, 1'b0);
    check("R6 set swap", status, 32'h0000_105C);
    csr_rd("R5 shadow copy", 2'd2, 32'h0003_0051);
    csr_rd("R5 esave untouched", 2'd1, 32'h0000_0123);
    pulse_exc();
    check("R4 nested exc", status, 32'h0000_105C);
    csr_rd("R5 nested no save", 2'd1, 32'h0000_0123);
    csr_rd("R5 nested no shadow", 2'd2, 32'h0003_0051);
    pulse_eret();
    check("R8 restore shadow", status, 32'h0003_0051);
  endtask

  task automatic t_exc_priority();
    csr_wr(2'd0, 32'h0);
    check("R7 write zero", status, 32'h0);
    @(negedge clk);
    irq = 1'b1; irq_level = 6'd9;
    #1 check("R2 disabled", {31'b0, take}, 32'h0);
    irq = 1'b0;
    pulse_exc();
    check("R4 exc while disabled", status, 32'h4);
    csr_rd("R5 exc save", 2'd1, 32'h0);
    csr_wr(2'd0, 32'h51);
    pulse_irq(6'd9, 1'b0, 6'd0, 1'b1);
    check("R4 exc beats irq", status, 32'h54);
    csr_rd("R5 exc save prio", 2'd1, 32'h51);
    csr_rd("R5 shadow kept", 2'd2, 32'h0003_0051);
    pulse_eret();
    check("R8 restore after exc", status, 32'h51);
  endtask

  task automatic t_illegal();
    csr_wr(2'd0, 32'h7);
    check("R9 user forced 0", status, 32'h5);
    check("R9 flag", {31'b0, illegal}, 32'h1);
    @(negedge clk);
    check("R9 flag one cycle", {31'b0, illegal}, 32'h0);
    csr_wr(2'd0, 32'h3);
    check("R9 legal user", status, 32'h3);
    check("R9 no flag", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_save_rw();
    csr_wr(2'd1, 32'hFFFF_FFFF);
    csr_rd("R10 esave mask", 2'd1, 32'h003F_FFFF);
    csr_wr(2'd2, 32'hABCD_EF12);
    csr_rd("R10 ssave mask", 2'd2, 32'h000D_EF12);
    csr_rd("R10 sel 3", 2'd3, 32'h0);
  endtask

  task automatic t_configs();
    csr_wr(2'd0, 32'hFFFF_FFFF);
    check("R9 all ones", status, 32'h003F_03FD);
    check("R9 all ones flag", {31'b0, illegal}, 32'h1);
    check("R11 no-mmu status", status_nm, 32'h0000_03F9);
    check("R11 no-mmu flag", {31'b0, illegal_nm}, 32'h0);
    csr_sel = 2'd2;
    #1 check("R11 no shadow save", rdata_nm, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_status();
    t_level_gate();
    t_irq_entry();
    t_shadow_nested();
    t_exc_priority();
    t_illegal();
    t_save_rw();
    t_configs();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule